// File: doc/BRIEF.md
# Read Burst Output Timer

This block decides when read data leaves a synchronous burst SRAM. An arbiter pulses a one-cycle read strobe, which is sampled on the rising clock edge. The block then produces three outputs at half-cycle resolution: a data-output enable, a word index for the four-word burst, and a data-valid flag. The flag rises half a cycle ahead of the first data word, so a receiver can prepare its capture before the data arrives.

The high clock phase and the low clock phase each form one output slot. The first word always falls in a high phase. A static mode input selects the read latency. With the clock-alignment loop enabled the latency is 2.0 cycles. In the bypass legacy mode the latency is 1.0 cycle. Reads spaced exactly two cycles apart give an unbroken output stream.

Top module: `rd_burst_timer`

## Requirements
- R1: While rst_ni is low, dout_en_o and q_valid_o are 0 and word_idx_o is 0.
- R2: With pll_en_i = 1, a read sampled at rising edge E drives word 0 in the high phase that starts two full cycles after E.
- R3: With pll_en_i = 0, a read sampled at rising edge E drives word 0 in the high phase that starts one cycle after E.
- R4: A burst takes four consecutive half-cycle slots. In those slots dout_en_o is 1 and word_idx_o counts 0, 1, 2, 3. Even indices fall in high phases and odd indices in low phases.
- R5: q_valid_o rises in the low phase just before word 0 and stays high through the slots of words 0, 1 and 2.
- R6: During the slot of word 3, q_valid_o is 0 unless word 0 of another burst follows in the next slot.
- R7: Reads sampled exactly two cycles apart keep dout_en_o and q_valid_o high without a gap, and word_idx_o wraps from 3 to 0.
- R8: When dout_en_o is 0, word_idx_o is 0.
- R9: Input rules: rising edges that sample a read are at least two cycles apart. pll_en_i changes only when no burst is in flight, meaning from the sampling edge to the end of the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock; both edges are used |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pll_en_i | input | 1 | Static latency mode: 1 = 2.0 cycles, 0 = 1.0 cycle |
| rd_start_i | input | 1 | Read strobe from the arbiter, sampled on the rising edge |
| q_valid_o | output | 1 | Data-valid flag, leads the data by half a cycle |
| dout_en_o | output | 1 | Data-output enable, high in each slot that carries a burst word |
| word_idx_o | output | 2 | Index of the burst word in the current slot |

## Verification
The assertions take the R9 input rules for granted. No two reads are sampled less than two cycles apart, so at most one burst owns any slot. The mode input changes only after the last burst has drained. The stimulus uses only three read patterns: a single read, reads exactly two cycles apart, and reads three or more cycles apart. It changes pll_en_i only after a long idle stretch. A reference model in the bench keeps a queue of read start slots and computes the expected value of every output in every half cycle.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
  typedef enum logic {
    MODE_LEGACY = 1'b0,
    MODE_PLL    = 1'b1
  } lat_mode_e;

  // true when off lies in [lo, lo+len)
  function automatic logic in_span(input int off, input int lo, input int len);
    return (off >= lo) && (off < lo + len);
  endfunction
endpackage

// File: rtl/rbt_history.sv
module rbt_history #(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  output logic [DEPTH-1:0] hist_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], rd_i};
  end

  assign hist_o = sr_q;
endmodule

// File: rtl/rbt_phase_decode.sv
module rbt_phase_decode #(
  parameter int BURST_LEN = 4,
  parameter int DEPTH     = 4,
  parameter int IDX_W     = 2,
  parameter int LAT_W     = 3,
  parameter bit ODD       = 1'b0
) (
  input  logic [DEPTH-1:0] hist_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             valid_o,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o
);
  import rbt_pkg::*;

  localparam int PH = ODD ? 1 : 0;

  // hist_i[n] = read sampled n cycles back; slot offset = 2n + phase
  always_comb begin
    int off;
    valid_o = 1'b0;
    oe_o    = 1'b0;
    idx_o   = '0;
    off     = 0;
    for (int n = 0; n < DEPTH; n++) begin
      off = 2 * n + PH - int'(lat_i);
      if (hist_i[n]) begin
        if (in_span(off, 0, BURST_LEN)) begin
          oe_o  = 1'b1;
          idx_o = IDX_W'(off);
        end
        if (in_span(off, -1, BURST_LEN)) valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rbt_low_stage.sv
module rbt_low_stage #(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             oe_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             valid_o,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      oe_o    <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= valid_i;
      oe_o    <= oe_i;
      idx_o   <= idx_i;
    end
  end
endmodule

// File: rtl/rd_burst_timer.sv
module rd_burst_timer #(
  parameter int BURST_LEN       = 4,
  parameter int LAT_PLL_HALF    = 4,
  parameter int LAT_LEGACY_HALF = 2,
  localparam int IDX_W          = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pll_en_i,
  input  logic             rd_start_i,
  output logic             q_valid_o,
  output logic             dout_en_o,
  output logic [IDX_W-1:0] word_idx_o
);
  import rbt_pkg::*;

  localparam int LAT_MAX = (LAT_PLL_HALF > LAT_LEGACY_HALF) ? LAT_PLL_HALF : LAT_LEGACY_HALF;
  localparam int DEPTH   = (LAT_MAX + BURST_LEN) / 2;
  localparam int LAT_W   = $clog2(LAT_MAX + 1);

  lat_mode_e        mode;
  logic [LAT_W-1:0] lat_half;
  logic [DEPTH-1:0] hist;

  assign mode     = lat_mode_e'(pll_en_i);
  assign lat_half = (mode == MODE_PLL) ? LAT_W'(LAT_PLL_HALF) : LAT_W'(LAT_LEGACY_HALF);

  rbt_history #(.DEPTH(DEPTH)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (rd_start_i),
    .hist_o (hist)
  );

  logic             hi_valid, hi_oe, lo_valid_d, lo_oe_d, lo_valid_q, lo_oe_q;
  logic [IDX_W-1:0] hi_idx, lo_idx_d, lo_idx_q;

  // high phase: decoded straight from history updated on the rising edge
  rbt_phase_decode #(
    .BURST_LEN(BURST_LEN), .DEPTH(DEPTH), .IDX_W(IDX_W), .LAT_W(LAT_W), .ODD(1'b0)
  ) u_dec_hi (
    .hist_i (hist), .lat_i (lat_half),
    .valid_o(hi_valid), .oe_o(hi_oe), .idx_o(hi_idx)
  );

  // low phase: decoded then held on the falling edge
  rbt_phase_decode #(
    .BURST_LEN(BURST_LEN), .DEPTH(DEPTH), .IDX_W(IDX_W), .LAT_W(LAT_W), .ODD(1'b1)
  ) u_dec_lo (
    .hist_i (hist), .lat_i (lat_half),
    .valid_o(lo_valid_d), .oe_o(lo_oe_d), .idx_o(lo_idx_d)
  );

  rbt_low_stage #(.IDX_W(IDX_W)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(lo_valid_d), .oe_i(lo_oe_d), .idx_i(lo_idx_d),
    .valid_o(lo_valid_q), .oe_o(lo_oe_q), .idx_o(lo_idx_q)
  );

  // double-rate output select
  assign q_valid_o  = clk_i ? hi_valid : lo_valid_q;
  assign dout_en_o  = clk_i ? hi_oe    : lo_oe_q;
  assign word_idx_o = clk_i ? hi_idx   : lo_idx_q;
endmodule

// File: rtl/rbt_checker.sv
module rbt_checker #(
  parameter int BURST_LEN    = 4,
  parameter int LAT_PLL_HALF = 4,
  parameter int IDX_W        = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pll_en_i,
  input logic             rd_start_i,
  input logic             q_valid_o,
  input logic             dout_en_o,
  input logic [IDX_W-1:0] word_idx_o
);
  localparam int GAP_MIN = BURST_LEN / 2;
  localparam int FLIGHT  = (LAT_PLL_HALF + BURST_LEN) / 2 - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BURST_LEN - 1);

  int gap_cnt, fl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt <= 0;
      fl_cnt  <= 0;
    end else begin
      gap_cnt <= rd_start_i ? GAP_MIN - 1 : (gap_cnt > 0 ? gap_cnt - 1 : 0);
      fl_cnt  <= rd_start_i ? FLIGHT : (fl_cnt > 0 ? fl_cnt - 1 : 0);
    end
  end

  // sampled at falling edge = high-phase values; at rising edge = low-phase values
  assert_idx_idle_hi_R8: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> word_idx_o == '0);
  assert_idx_idle_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_en_o |-> word_idx_o == '0);
  assert_even_in_high_R4: assert property (@(negedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> !word_idx_o[0]);
  assert_odd_in_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> word_idx_o[0]);
  assert_valid_high_words_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> q_valid_o);
  assert_valid_low_words_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_o && word_idx_o != LAST_IDX) |-> q_valid_o);
  assert_read_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |-> gap_cnt == 0);
  assert_mode_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_en_i) |-> fl_cnt == 0);
endmodule

bind rd_burst_timer rbt_checker #(
  .BURST_LEN(BURST_LEN), .LAT_PLL_HALF(LAT_PLL_HALF), .IDX_W(IDX_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pll_en_i(pll_en_i), .rd_start_i(rd_start_i),
  .q_valid_o(q_valid_o), .dout_en_o(dout_en_o), .word_idx_o(word_idx_o)
);

// File: tb/tb_rd_burst_timer.sv
module tb_rd_burst_timer;
  localparam int BL = 4, LP = 4, LL = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pll_en_i = 1'b1;
  logic       rd_start_i = 1'b0;
  logic       q_valid_o, dout_en_o;
  logic [1:0] word_idx_o;

  always #10 clk_i = ~clk_i;

  rd_burst_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pll_en_i(pll_en_i), .rd_start_i(rd_start_i),
    .q_valid_o(q_valid_o), .dout_en_o(dout_en_o), .word_idx_o(word_idx_o)
  );

  int    errors = 0, checks = 0, edge_no = -1;
  int    starts[$];
  bit    done = 0;
  string phase = "";

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s slot=%0d actual=%0d expected=%0d", req, what, 2 * edge_no, act, exp);
    end
  endtask

  // reference: slot s, each read start slot r, offset d = s - r
  task automatic model_check(int s);
    int lat, ev, eo, ei;
    lat = pll_en_i ? LP : LL;
    ev = 0; eo = 0; ei = 0;
    foreach (starts[k]) begin
      int d;
      d = s - starts[k];
      if (d >= lat && d < lat + BL) begin eo = 1; ei = d - lat; end
      if (d >= lat - 1 && d < lat + BL - 1) ev = 1;
    end
    cmp({pll_en_i ? "R2" : "R3", phase}, "dout_en", int'(dout_en_o), eo);
    cmp({eo ? "R4" : "R8", phase}, "word_idx", int'(word_idx_o), ei);
    cmp({(!ev && eo) ? "R6" : "R5", phase}, "q_valid", int'(q_valid_o), ev);
  endtask

  always @(posedge clk_i) begin
    edge_no++;
    if (rst_ni && rd_start_i) starts.push_back(2 * edge_no);
  end

  always @(posedge clk_i) begin
    #5;
    if (rst_ni && !done) model_check(2 * edge_no);
  end

  always @(negedge clk_i) begin
    #5;
    if (rst_ni && !done) model_check(2 * edge_no + 1);
  end

  task automatic cyc(bit rd);
    @(negedge clk_i);
    #5;
    rd_start_i = rd;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0);
  endtask

  initial begin
    // R1 reset state in both phases
    repeat (2) @(posedge clk_i);
    #5;
    cmp("R1", "dout_en", int'(dout_en_o), 0);
    cmp("R1", "q_valid", int'(q_valid_o), 0);
    cmp("R1", "word_idx", int'(word_idx_o), 0);
    @(negedge clk_i);
    #5;
    cmp("R1", "dout_en", int'(dout_en_o), 0);
    cmp("R1", "q_valid", int'(q_valid_o), 0);
    rst_ni = 1'b1;

    // PLL mode: single reads (R2, R5, R6)
    cyc(1); idle(6);
    cyc(1); idle(3);
    // reads three cycles apart
    cyc(1); cyc(0); cyc(0); cyc(1); idle(6);
    // R7 back to back, two cycles apart
    phase = "/R7";
    for (int i = 0; i < 5; i++) begin cyc(1); cyc(0); end
    idle(6);
    phase = "";

    // legacy mode (R3)
    pll_en_i = 1'b0;
    idle(3);
    cyc(1); idle(5);
    cyc(1); cyc(0); cyc(0); cyc(1); idle(5);
    phase = "/R7";
    for (int i = 0; i < 4; i++) begin cyc(1); cyc(0); end
    idle(5);
    phase = "";

    // back to PLL mode, read right after the switch
    pll_en_i = 1'b1;
    idle(2);
    cyc(1); cyc(0); cyc(1); idle(8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule